// File: doc/BRIEF.md
# In-Band Loop Code Generator

This block drives a T1 serial line, one bit per clock, with a short user-chosen pattern repeated without end. It is typically used to send loop-up and loop-down codes toward a remote line unit. The pattern sits left-justified in an 8-bit code register and goes out starting at the most significant bit. A 2-bit length selector picks how many leading bits form one repetition. As an example, the code `0x80` with length 5 gives `10000` over and over.

The line carries a framing bit once every 193 bit times. A frame-position input marks that slot. When insertion is on, the slot carries an externally supplied F-bit in place of the pattern. The pattern position does not advance during the slot, so the code keeps its phase from one frame to the next. While the loop enable is low, the line idles at all ones.

The code and control registers are loaded through a simple write port. A changed code or length does not cut a repetition short. It takes effect at the next repetition boundary.

Top module: `loopcode_gen`

## Requirements
- R1: During and after reset, `tx_bit` is 1. Reset leaves the code register at 0x00, the length selector at 00 (length 5) and F-bit insertion on.
- R2: While `loop_en` is low, `tx_bit` is 1 on the following cycle. Once enabled again, the pattern restarts at the most significant bit of the code.
- R3: While enabled, the bits of each repetition go out most significant bit first, with one clock of latency. The length selector maps to lengths as follows: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8.
- R4: A write with `wr_addr`=0 loads `wr_data` into the code register. A write with `wr_addr`=1 loads the control register: bits 1:0 are the length selector and bit 2 is the F-bit insert enable (1 = insert). Bits 7:3 of a control write are ignored.
- R5: A code or length written during a repetition takes effect only at the next repetition boundary, or at once while the block is disabled. A write made in the same cycle as the last bit of a repetition waits for the boundary after that.
- R6: When enabled, with insertion on and `fslot` high, the next `tx_bit` equals `fbit_in`. The pattern index is held across that slot.
- R7: With insertion off, `fslot` and `fbit_in` are ignored, and the pattern fills every bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = code register, 1 = control register |
| wr_data | input | 8 | Write data |
| loop_en | input | 1 | Pattern transmission enable |
| fslot | input | 1 | High in the framing bit slot |
| fbit_in | input | 1 | Framing bit to send in that slot |
| tx_bit | output | 1 | Serial output, registered |

## Verification
The hardest case to reach is a framing slot that lands in the middle of a repetition, right after a register write made mid-repetition. This is where a held index, a deferred code load and the 193-bit frame spacing all meet. The stimulus runs long stretches with a framing slot every 193 cycles and uses lengths that do not divide 193, so the slot walks through every pattern phase. Code and length writes are issued at arbitrary points inside repetitions, including on the final bit of one. A cycle-accurate reference model in the driver predicts every output bit, and the monitor compares each one.

// File: rtl/lcg_pkg.sv
package lcg_pkg;

    typedef enum logic {
        ADDR_CODE = 1'b0,
        ADDR_CTRL = 1'b1
    } lcg_addr_e;

    // Force a table entry into the legal 1..maxv range.
    function automatic int clamp_len(int raw, int maxv);
        if (raw < 1) return 1;
        if (raw > maxv) return maxv;
        return raw;
    endfunction

endpackage

// File: rtl/lcg_len_map.sv
module lcg_len_map #(
    parameter int CODE_W = 8,
    parameter int LSEL_W = 2,
    parameter int LEN_W  = 4,
    parameter logic [(1<<LSEL_W)*LEN_W-1:0] MAP = 16'h8765
) (
    input  logic [LSEL_W-1:0] sel,
    output logic [LEN_W-1:0]  len
);
    localparam int N = 1 << LSEL_W;

    logic [LEN_W-1:0] tbl [N];

    for (genvar i = 0; i < N; i++) begin : g_ent
        localparam int RAW = int'(MAP[i*LEN_W +: LEN_W]);
        assign tbl[i] = LEN_W'(lcg_pkg::clamp_len(RAW, CODE_W));
    end

    assign len = tbl[sel];

endmodule

// File: rtl/lcg_seq.sv
module lcg_seq #(
    parameter int CODE_W = 8,
    parameter int LEN_W  = 4,
    parameter int IDX_W  = 3,
    parameter logic [LEN_W-1:0] RST_LEN = 4'd5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loop_en,
    input  logic              fslot_ins,
    input  logic              fbit_in,
    input  logic [CODE_W-1:0] nxt_code,
    input  logic [LEN_W-1:0]  nxt_len,
    output logic              tx_bit
);
    typedef struct packed {
        logic              tx;
        logic [IDX_W-1:0]  idx;
        logic [CODE_W-1:0] code;
        logic [LEN_W-1:0]  len;
    } seq_t;

    seq_t s_q, s_d;
    logic wrap;

    always_comb begin
        s_d  = s_q;
        wrap = (LEN_W'(s_q.idx) == (s_q.len - LEN_W'(1)));
        if (!loop_en) begin
            // idle: send ones, park at the first bit, follow the staged setup
            s_d.tx   = 1'b1;
            s_d.idx  = '0;
            s_d.code = nxt_code;
            s_d.len  = nxt_len;
        end else if (fslot_ins) begin
            // framing slot overwrites the line, pattern phase is frozen
            s_d.tx = fbit_in;
        end else begin
            s_d.tx = s_q.code[IDX_W'(CODE_W-1) - s_q.idx];
            if (wrap) begin
                s_d.idx  = '0;
                s_d.code = nxt_code;
                s_d.len  = nxt_len;
            end else begin
                s_d.idx = s_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.tx   <= 1'b1;
            s_q.idx  <= '0;
            s_q.code <= '0;
            s_q.len  <= RST_LEN;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_bit = s_q.tx;

endmodule

// File: rtl/loopcode_gen.sv
module loopcode_gen #(
    parameter int CODE_W = 8,
    parameter int LSEL_W = 2,
    parameter int LEN_W  = $clog2(CODE_W + 1),
    parameter logic [(1<<LSEL_W)*LEN_W-1:0] LEN_MAP = 16'h8765
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [CODE_W-1:0] wr_data,
    input  logic              loop_en,
    input  logic              fslot,
    input  logic              fbit_in,
    output logic              tx_bit
);
    import lcg_pkg::*;

    localparam int IDX_W    = (CODE_W > 1) ? $clog2(CODE_W) : 1;
    localparam int FINS_BIT = LSEL_W;
    localparam logic [LEN_W-1:0] RST_LEN =
        LEN_W'(clamp_len(int'(LEN_MAP[LEN_W-1:0]), CODE_W));

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [LSEL_W-1:0] lsel;
        logic              fins;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [LEN_W-1:0] sel_len;
    logic             fslot_ins;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (lcg_addr_e'(wr_addr) == ADDR_CODE) begin
                cfg_d.code = wr_data;
            end else begin
                cfg_d.lsel = wr_data[LSEL_W-1:0];
                cfg_d.fins = wr_data[FINS_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.code <= '0;
            cfg_q.lsel <= '0;
            cfg_q.fins <= 1'b1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign fslot_ins = fslot & cfg_q.fins;

    lcg_len_map #(
        .CODE_W (CODE_W),
        .LSEL_W (LSEL_W),
        .LEN_W  (LEN_W),
        .MAP    (LEN_MAP)
    ) u_map (
        .sel (cfg_q.lsel),
        .len (sel_len)
    );

    lcg_seq #(
        .CODE_W  (CODE_W),
        .LEN_W   (LEN_W),
        .IDX_W   (IDX_W),
        .RST_LEN (RST_LEN)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .loop_en   (loop_en),
        .fslot_ins (fslot_ins),
        .fbit_in   (fbit_in),
        .nxt_code  (cfg_q.code),
        .nxt_len   (sel_len),
        .tx_bit    (tx_bit)
    );

endmodule

// File: rtl/lcg_chk.sv
module lcg_chk #(
    parameter int CODE_W = 8,
    parameter int LEN_W  = 4,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              loop_en,
    input logic              fslot_ins,
    input logic              fbit_in,
    input logic              tx_bit,
    input logic [IDX_W-1:0]  idx,
    input logic [CODE_W-1:0] code,
    input logic [LEN_W-1:0]  len
);
    // R2
    idle_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en |=> tx_bit);

    // R2
    idle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en |=> (idx == '0));

    // R6
    fbit_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en && fslot_ins) |=> (tx_bit == $past(fbit_in)));

    // R6
    fslot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en && fslot_ins) |=> $stable(idx));

    // R3
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        LEN_W'(idx) < len);

    // R5
    mid_rep_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx != '0) |-> ($stable(code) && $stable(len)));

endmodule

bind lcg_seq lcg_chk #(
    .CODE_W (CODE_W),
    .LEN_W  (LEN_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .loop_en   (loop_en),
    .fslot_ins (fslot_ins),
    .fbit_in   (fbit_in),
    .tx_bit    (tx_bit),
    .idx       (s_q.idx),
    .code      (s_q.code),
    .len       (s_q.len)
);

// File: tb/loopcode_gen_tb.sv
module loopcode_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       loop_en = 1'b0;
    logic       fslot = 1'b0;
    logic       fbit_in = 1'b0;
    logic       tx_bit;

    always #2 clk = ~clk;

    loopcode_gen u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .loop_en (loop_en),
        .fslot   (fslot),
        .fbit_in (fbit_in),
        .tx_bit  (tx_bit)
    );

    typedef struct {
        logic  exp;
        string req;
    } item_t;

    item_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    logic [7:0] m_pcode = 8'h00;
    logic [1:0] m_plsel = 2'b00;
    logic       m_pfins = 1'b1;
    logic [7:0] m_acode = 8'h00;
    int         m_alen  = 5;
    int         m_idx   = 0;

    // driver: called just after a falling edge
    task automatic step(input logic en, input logic fs, input logic fb,
                        input logic we, input logic wa, input logic [7:0] wd,
                        input string req);
        item_t it;
        loop_en = en; fslot = fs; fbit_in = fb;
        wr_en = we; wr_addr = wa; wr_data = wd;
        if (!en) begin
            it.exp = 1'b1;
            m_idx = 0; m_acode = m_pcode; m_alen = 5 + int'(m_plsel);
        end else if (fs && m_pfins) begin
            it.exp = fb;
        end else begin
            it.exp = m_acode[7 - m_idx];
            if (m_idx == m_alen - 1) begin
                m_idx = 0; m_acode = m_pcode; m_alen = 5 + int'(m_plsel);
            end else begin
                m_idx++;
            end
        end
        if (we) begin
            if (!wa) m_pcode = wd;
            else begin m_plsel = wd[1:0]; m_pfins = wd[2]; end
        end
        it.req = req;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic run(input logic en, input int n, input string req);
        for (int i = 0; i < n; i++) step(en, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, req);
    endtask

    task automatic wr(input logic en, input logic wa, input logic [7:0] wd, input string req);
        step(en, 1'b0, 1'b0, 1'b1, wa, wd, req);
    endtask

    // monitor: compares just after each rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_cmp++;
            if (tx_bit !== it.exp) begin
                n_bad++;
                $display("FAIL %s: tx_bit=%0b expected %0b at %0t", it.req, tx_bit, it.exp, $time);
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: ran=1 expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: idle level during reset
        #9;
        n_cmp++;
        if (tx_bit !== 1'b1) begin
            n_bad++;
            $display("FAIL R1: tx_bit=%0b expected 1 in reset", tx_bit);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset code 00 length 5, enabled straight away -> zeros
        run(1'b1, 12, "R1");
        // R2: disable mid-repetition gives ones
        run(1'b0, 4, "R2");

        // R4: code 0x80, length 5
        wr(1'b0, 1'b0, 8'h80, "R4");
        run(1'b0, 2, "R4");
        run(1'b1, 20, "R3");

        // R3: each length with a distinct code, selected while idle
        wr(1'b0, 1'b0, 8'hA5, "R4");
        wr(1'b0, 1'b1, 8'h01, "R4");
        run(1'b0, 1, "R2");
        run(1'b1, 18, "R3");
        run(1'b0, 1, "R2");
        wr(1'b0, 1'b1, 8'h02, "R4");
        wr(1'b0, 1'b0, 8'hD3, "R4");
        run(1'b1, 21, "R3");
        run(1'b0, 1, "R2");
        wr(1'b0, 1'b1, 8'h03, "R4");
        wr(1'b0, 1'b0, 8'hB6, "R4");
        run(1'b1, 24, "R3");

        // R2: disable mid pattern and restart at the first bit
        run(1'b1, 3, "R3");
        run(1'b0, 2, "R2");
        run(1'b1, 10, "R2");

        // R5: writes mid-repetition and on the last bit
        wr(1'b1, 1'b0, 8'h0F, "R5");
        run(1'b1, 9, "R5");
        wr(1'b1, 1'b1, 8'h04, "R5");
        run(1'b1, 12, "R5");
        for (int i = 0; i < 40; i++) begin
            if (m_idx == m_alen - 1) begin
                wr(1'b1, 1'b0, 8'h3C, "R5");
                break;
            end
            step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R5");
        end
        run(1'b1, 20, "R5");

        // R4: control write with upper bits set (length 6, insertion on)
        wr(1'b1, 1'b1, 8'hFD, "R4");
        run(1'b1, 14, "R4");

        // R6: framing slot every 193 bits, alternating F values
        for (int i = 0; i < 193 * 6; i++) begin
            logic fs;
            fs = (i % 193) == 0;
            step(1'b1, fs, ((i / 193) % 2) == 0, 1'b0, 1'b0, 8'h00, fs ? "R6" : "R3");
        end
        // R6 with length 7 and a mid-stream code change
        wr(1'b1, 1'b1, 8'h06, "R6");
        wr(1'b1, 1'b0, 8'h80, "R6");
        for (int i = 0; i < 193 * 4; i++) begin
            logic fs;
            fs = (i % 193) == 100;
            step(1'b1, fs, 1'b1, 1'b0, 1'b0, 8'h00, "R6");
        end

        // R7: insertion off, slots ignored
        wr(1'b1, 1'b1, 8'h01, "R7");
        for (int i = 0; i < 193 * 4; i++) begin
            logic fs;
            fs = (i % 193) == 7;
            step(1'b1, fs, ~m_acode[7 - m_idx], 1'b0, 1'b0, 8'h00, "R7");
        end
        run(1'b0, 3, "R2");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule